// File: doc/BRIEF.md
# Receive Destination Address Filter

This block decides, for each received Ethernet frame, whether it should be kept or dropped. The decision depends only on the 48-bit destination address, which upstream logic has already pulled out of the frame. The filter holds a bank of exact-match address entries and a 64-bit multicast hash table. It also holds two control bits: one makes it keep every frame, and the other makes it keep every multicast frame. All of this state is loaded through a plain register write port.

Destination addresses enter on a valid/ready stream. The verdict leaves one cycle later on a second valid/ready stream, together with the reason for the verdict and the index of the exact entry that matched. The two streams are tied by a single register stage. A new address is taken only when the result register is empty, or when its current result is being consumed in the same cycle. While the consumer holds `res_ready` low, a pending result stays frozen and `addr_ready` stays low. This is how the consumer's back-pressure reaches the address source.

Address byte 0 is the first byte on the wire and sits in `da[7:0]`; byte 5 sits in `da[47:40]`. Bit `da[0]` is therefore the group (multicast) bit.

Top module: `rx_daddr_filter`

## Requirements
- R1: After reset, every exact entry, both hash words and both control bits are zero, `res_valid` is 0 and `addr_ready` is 1. A unicast or non-broadcast multicast address sent right after reset is dropped.
- R2: Exact entry i is loaded as two words. The low word, at register address 2i, carries address bytes 3..0 from its MSB down to its LSB, so it equals `da[31:0]`. The high word, at register address 2i+1, carries bytes 5 and 4 in its bits 15:0, so those bits equal `da[47:32]`.
- R3: If a destination equals one or more exact entries, the frame is accepted with source code 1 (exact). `res_idx` is the lowest matching entry index. An exact match takes priority over every other source.
- R4: The broadcast address (all ones) is accepted with source code 2 whenever no exact entry matches.
- R5: The hash index is 6 bits. Bit j of the index is the XOR of every `da[k]` for which k mod 6 equals j. Hash bits 0..31 are set through the register at address 2N (bit n = hash bit n). Hash bits 32..63 are set through the register at address 2N+1 (bit n = hash bit 32+n). Here N is the number of exact entries. A multicast, non-broadcast destination whose hash bit is set is accepted with source code 3.
- R6: A unicast destination (`da[0]` = 0) is never accepted through the hash table or the accept-all-multicast control, even when the whole table is ones.
- R7: The control register sits at address 2N+2, and its bit 1 turns on accept-all-multicast. With this bit set, a multicast destination that no exact entry, broadcast check or hash bit claims is accepted with source code 4.
- R8: Bit 0 of the control register turns on promiscuous mode. In this mode, a frame that no other source claims is accepted with source code 5. Sources rank as exact > broadcast > hash > accept-all-multicast > promiscuous.
- R9: A frame that no source claims is dropped: `res_accept` is 0, `res_src` is 0 and `res_idx` is 0. A result that is accepted never carries source code 0.
- R10: A result appears on the clock edge after the address handshake. While `res_valid` is high and `res_ready` is low, the result is held stable and `addr_ready` is low. An address offered in that time is taken on the edge where the held result is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | CFG_AW | Register word address |
| cfg_wdata | input | 32 | Register write data |
| addr_valid | input | 1 | Destination address offered |
| addr_ready | output | 1 | Filter can take the address this cycle |
| da | input | 48 | Destination address, byte 0 in bits 7:0 |
| res_valid | output | 1 | Verdict present |
| res_ready | input | 1 | Consumer takes the verdict |
| res_accept | output | 1 | 1 = keep frame, 0 = drop |
| res_src | output | 3 | Reason: 0 none, 1 exact, 2 broadcast, 3 hash, 4 all-multicast, 5 promiscuous |
| res_idx | output | IDX_W | Matching exact entry index (0 unless source is exact) |

## Verification
The bench builds the filter with its default of eight exact entries. This places the hash words at addresses 16 and 17 and the control register at 18, and gives a 3-bit entry index. With eight entries the bench can load the station entry, two entries that hold the same address (to test the lowest-index rule) and a spare multicast entry. It can then search candidate multicast addresses until it finds one whose hash index lands in each half of the table. Random destinations are checked against a model that the bench builds from R3 to R9, under each control setting in turn.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int MAC_W    = 48;
  localparam int HASH_W   = 6;
  localparam int HASH_N   = 1 << HASH_W;
  localparam int WORD_W   = 32;

  typedef enum logic [2:0] {
    SRC_NONE    = 3'd0,
    SRC_EXACT   = 3'd1,
    SRC_BCAST   = 3'd2,
    SRC_HASH    = 3'd3,
    SRC_ALLMC   = 3'd4,
    SRC_PROMISC = 3'd5
  } src_e;

  // Address bits that fold into hash index bit j.
  function automatic logic [MAC_W-1:0] fold_mask(input int j);
    logic [MAC_W-1:0] m;
    m = '0;
    for (int k = 0; k < MAC_W; k++)
      if ((k % HASH_W) == j) m[k] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/rxf_cfg_regs.sv
module rxf_cfg_regs
  import rxf_pkg::*;
#(
  parameter int N_EXACT = 8,
  parameter int CFG_AW  = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [CFG_AW-1:0]             cfg_addr,
  input  logic [WORD_W-1:0]             cfg_wdata,
  output logic [N_EXACT-1:0][MAC_W-1:0] entries,
  output logic [HASH_N-1:0]             hash_tbl,
  output logic                          copy_all,
  output logic                          all_multi
);
  localparam logic [CFG_AW-1:0] HASH_LO_A = CFG_AW'(2*N_EXACT);
  localparam logic [CFG_AW-1:0] HASH_HI_A = CFG_AW'(2*N_EXACT + 1);
  localparam logic [CFG_AW-1:0] CTRL_A    = CFG_AW'(2*N_EXACT + 2);
  localparam int HI_W = MAC_W - WORD_W;

  for (genvar i = 0; i < N_EXACT; i++) begin : g_ent
    localparam logic [CFG_AW-1:0] LO_A = CFG_AW'(2*i);
    localparam logic [CFG_AW-1:0] HI_A = CFG_AW'(2*i + 1);
    logic [MAC_W-1:0] ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q <= '0;
      end else if (cfg_we) begin
        if (cfg_addr == LO_A) ent_q[WORD_W-1:0]     <= cfg_wdata;
        if (cfg_addr == HI_A) ent_q[MAC_W-1:WORD_W] <= cfg_wdata[HI_W-1:0];
      end
    end
    assign entries[i] = ent_q;
  end

  logic [WORD_W-1:0] hlo_q, hhi_q;
  logic              copy_q, amc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hlo_q  <= '0;
      hhi_q  <= '0;
      copy_q <= 1'b0;
      amc_q  <= 1'b0;
    end else if (cfg_we) begin
      if (cfg_addr == HASH_LO_A) hlo_q <= cfg_wdata;
      if (cfg_addr == HASH_HI_A) hhi_q <= cfg_wdata;
      if (cfg_addr == CTRL_A) begin
        copy_q <= cfg_wdata[0];
        amc_q  <= cfg_wdata[1];
      end
    end
  end

  assign hash_tbl  = {hhi_q, hlo_q};
  assign copy_all  = copy_q;
  assign all_multi = amc_q;
endmodule

// File: rtl/rxf_hash_fold.sv
module rxf_hash_fold
  import rxf_pkg::*;
(
  input  logic [MAC_W-1:0]  da,
  output logic [HASH_W-1:0] idx
);
  for (genvar j = 0; j < HASH_W; j++) begin : g_bit
    localparam logic [MAC_W-1:0] MASK = fold_mask(j);
    assign idx[j] = ^(da & MASK);
  end
endmodule

// File: rtl/rxf_exact_match.sv
module rxf_exact_match
  import rxf_pkg::*;
#(
  parameter int N_EXACT = 8,
  parameter int IDX_W   = 3
) (
  input  logic [MAC_W-1:0]              da,
  input  logic [N_EXACT-1:0][MAC_W-1:0] entries,
  output logic                          hit,
  output logic [IDX_W-1:0]              hit_idx
);
  logic [N_EXACT-1:0] eq;

  for (genvar i = 0; i < N_EXACT; i++) begin : g_cmp
    assign eq[i] = (entries[i] == da);
  end

  // Lowest index wins: scan downward so the last assignment is the lowest.
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = N_EXACT - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/rx_daddr_filter.sv
module rx_daddr_filter
  import rxf_pkg::*;
#(
  parameter int N_EXACT = 8,
  parameter int CFG_AW  = $clog2(2*N_EXACT + 3),
  parameter int IDX_W   = (N_EXACT > 1) ? $clog2(N_EXACT) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              addr_valid,
  output logic              addr_ready,
  input  logic [47:0]       da,
  output logic              res_valid,
  input  logic              res_ready,
  output logic              res_accept,
  output logic [2:0]        res_src,
  output logic [IDX_W-1:0]  res_idx
);
  logic [N_EXACT-1:0][MAC_W-1:0] entries;
  logic [HASH_N-1:0]             hash_tbl;
  logic                          copy_all, all_multi;
  logic [HASH_W-1:0]             hidx;
  logic                          hit;
  logic [IDX_W-1:0]              hit_idx;

  rxf_cfg_regs #(.N_EXACT(N_EXACT), .CFG_AW(CFG_AW)) u_regs (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata,
    .entries, .hash_tbl, .copy_all, .all_multi
  );

  rxf_hash_fold u_fold (.da(da), .idx(hidx));

  rxf_exact_match #(.N_EXACT(N_EXACT), .IDX_W(IDX_W)) u_cam (
    .da(da), .entries(entries), .hit(hit), .hit_idx(hit_idx)
  );

  logic             is_mc, is_bc;
  src_e             nxt_src;
  logic [IDX_W-1:0] nxt_idx;

  assign is_mc = da[0];
  assign is_bc = &da;

  always_comb begin
    nxt_src = SRC_NONE;
    nxt_idx = '0;
    if (hit) begin
      nxt_src = SRC_EXACT;
      nxt_idx = hit_idx;
    end else if (is_bc) begin
      nxt_src = SRC_BCAST;
    end else if (is_mc && hash_tbl[hidx]) begin
      nxt_src = SRC_HASH;
    end else if (is_mc && all_multi) begin
      nxt_src = SRC_ALLMC;
    end else if (copy_all) begin
      nxt_src = SRC_PROMISC;
    end
  end

  logic take;
  assign addr_ready = !res_valid || res_ready;
  assign take       = addr_valid && addr_ready;

  src_e src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      res_accept <= 1'b0;
      src_q      <= SRC_NONE;
      res_idx    <= '0;
    end else if (take) begin
      res_valid  <= 1'b1;
      res_accept <= (nxt_src != SRC_NONE);
      src_q      <= nxt_src;
      res_idx    <= nxt_idx;
    end else if (res_ready) begin
      res_valid  <= 1'b0;
    end
  end

  assign res_src = src_q;
endmodule

// File: rtl/rxf_filter_chk.sv
module rxf_filter_chk #(
  parameter int IDX_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             addr_valid,
  input logic             addr_ready,
  input logic [47:0]      da,
  input logic             res_valid,
  input logic             res_ready,
  input logic             res_accept,
  input logic [2:0]       res_src,
  input logic [IDX_W-1:0] res_idx,
  input logic             copy_all
);
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |=> res_valid && $stable(res_accept) && $stable(res_src) && $stable(res_idx)); // R10
  AST_STALL_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_ready |-> !addr_ready); // R10
  AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && addr_ready |=> res_valid); // R10
  AST_BCAST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && addr_ready && (&da) |=> res_accept); // R4
  AST_UCAST_NO_HASH: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && addr_ready && !da[0] |=> (res_src != 3'd3) && (res_src != 3'd4)); // R6
  AST_PROMISC_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid && addr_ready && copy_all |=> res_accept); // R8
  AST_DROP_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && !res_accept |-> (res_src == 3'd0) && (res_idx == '0)); // R9
  AST_ACCEPT_HAS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && res_accept |-> (res_src != 3'd0)); // R9
endmodule

bind rx_daddr_filter rxf_filter_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr_valid(addr_valid), .addr_ready(addr_ready),
  .da(da), .res_valid(res_valid), .res_ready(res_ready), .res_accept(res_accept),
  .res_src(res_src), .res_idx(res_idx), .copy_all(copy_all)
);

// File: tb/rx_daddr_filter_tb_top.sv
module rx_daddr_filter_tb_top;
  localparam int N  = 8;
  localparam int AW = 5;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic addr_valid = 1'b0;
  logic addr_ready;
  logic [47:0] da = '0;
  logic res_valid;
  logic res_ready = 1'b1;
  logic res_accept;
  logic [2:0] res_src;
  logic [IW-1:0] res_idx;

  always #2 clk = ~clk;  // 250 MHz

  rx_daddr_filter #(.N_EXACT(N)) dut_i (
    .clk, .rst_n, .cfg_we, .cfg_addr, .cfg_wdata, .addr_valid, .addr_ready,
    .da, .res_valid, .res_ready, .res_accept, .res_src, .res_idx
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;

  logic [47:0] sh_ent [N];
  logic [63:0] sh_hash;
  bit sh_copy, sh_amc;

  function automatic logic [5:0] hash_of(input logic [47:0] d);
    logic [5:0] h = '0;
    for (int k = 0; k < 48; k++) h[k % 6] ^= d[k];
    return h;
  endfunction

  // {accept, src[2:0], idx[2:0]}
  function automatic logic [6:0] model(input logic [47:0] d);
    for (int i = 0; i < N; i++)
      if (sh_ent[i] == d) return {1'b1, 3'd1, 3'(i)};
    if (&d) return {1'b1, 3'd2, 3'd0};
    if (d[0] && sh_hash[hash_of(d)]) return {1'b1, 3'd3, 3'd0};
    if (d[0] && sh_amc) return {1'b1, 3'd4, 3'd0};
    if (sh_copy) return {1'b1, 3'd5, 3'd0};
    return 7'd0;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic set_entry(input int i, input logic [47:0] d);
    wr(2*i, d[31:0]);
    wr(2*i + 1, {16'h0, d[47:32]});
    sh_ent[i] = d;
  endtask

  task automatic set_hash(input logic [63:0] h);
    wr(2*N, h[31:0]);
    wr(2*N + 1, h[63:32]);
    sh_hash = h;
  endtask

  task automatic set_ctrl(input bit cp, input bit am);
    wr(2*N + 2, {30'h0, am, cp});
    sh_copy = cp; sh_amc = am;
  endtask

  task automatic send(input logic [47:0] d, input string req);
    logic [6:0] e;
    e = model(d);
    @(negedge clk);
    addr_valid = 1'b1; da = d;
    @(posedge clk);
    @(negedge clk);
    addr_valid = 1'b0;
    chk(req, "valid", 32'(res_valid), 1);
    chk(req, "accept", 32'(res_accept), 32'(e[6]));
    chk(req, "src", 32'(res_src), 32'(e[5:3]));
    chk(req, "idx", 32'(res_idx), 32'(e[2:0]));
  endtask

  task automatic t_reset;
    chk("R1", "res_valid after reset", 32'(res_valid), 0);
    chk("R1", "addr_ready after reset", 32'(addr_ready), 1);
    send(48'h5544_3322_1102, "R1");
    chk("R1", "unicast dropped", 32'(res_accept), 0);
    send(48'h0000_5e00_0001, "R1");
    chk("R1", "multicast dropped", 32'(res_accept), 0);
  endtask

  task automatic t_exact;
    set_entry(0, 48'h6655_4433_2200);
    set_entry(3, 48'h0300_005e_0001);
    set_entry(5, 48'h0300_005e_0001);
    send(48'h6655_4433_2200, "R2");
    chk("R2", "station src", 32'(res_src), 1);
    chk("R2", "station idx", 32'(res_idx), 0);
    send(48'h0300_005e_0001, "R3");
    chk("R3", "lowest duplicate idx", 32'(res_idx), 3);
    send(48'h6655_4433_2201, "R9");
  endtask

  task automatic t_bcast;
    send(48'hffff_ffff_ffff, "R4");
    chk("R4", "bcast src", 32'(res_src), 2);
  endtask

  task automatic t_hash;
    logic [47:0] lo_a, hi_a;
    bit got_lo = 0, got_hi = 0;
    logic [63:0] h = '0;
    for (int b = 1; b < 256; b += 2) begin
      logic [47:0] d;
      d = {40'h77_1234_5678, 8'(b)};
      if (!got_lo && hash_of(d) < 32) begin lo_a = d; got_lo = 1; end
      if (!got_hi && hash_of(d) >= 32) begin hi_a = d; got_hi = 1; end
    end
    if (got_lo) h[hash_of(lo_a)] = 1'b1;
    if (got_hi) h[hash_of(hi_a)] = 1'b1;
    set_hash(h);
    if (got_lo) begin send(lo_a, "R5"); chk("R5", "low half hash src", 32'(res_src), 3); end
    if (got_hi) begin send(hi_a, "R5"); chk("R5", "high half hash src", 32'(res_src), 3); end
    send(48'h0a0b_0c0d_0e03, "R5");
    set_hash('1);
    send(48'h0a0b_0c0d_0e03, "R5");
    chk("R5", "all-ones table keeps multicast", 32'(res_accept), 1);
  endtask

  task automatic t_unicast;
    send(48'h0a0b_0c0d_0e02, "R6");
    chk("R6", "unicast ignores full table", 32'(res_accept), 0);
    set_ctrl(0, 1);
    send(48'h1a0b_0c0d_0e04, "R6");
    chk("R6", "unicast ignores all-multi", 32'(res_accept), 0);
  endtask

  task automatic t_allmulti;
    set_hash('0);
    send(48'h0a0b_0c0d_0e05, "R7");
    chk("R7", "all-multi src", 32'(res_src), 4);
    set_ctrl(0, 0);
    send(48'h0a0b_0c0d_0e05, "R7");
    chk("R7", "all-multi off drops", 32'(res_accept), 0);
  endtask

  task automatic t_promisc;
    set_ctrl(1, 0);
    send(48'h9988_7766_5544, "R8");
    chk("R8", "promisc src", 32'(res_src), 5);
    send(48'h6655_4433_2200, "R8");
    chk("R8", "exact outranks promisc", 32'(res_src), 1);
    send(48'hffff_ffff_ffff, "R8");
    chk("R8", "bcast outranks promisc", 32'(res_src), 2);
    set_ctrl(0, 0);
  endtask

  task automatic t_backpressure;
    logic [6:0] ea, eb;
    ea = model(48'h6655_4433_2200);
    eb = model(48'hffff_ffff_ffff);
    @(negedge clk);
    res_ready = 1'b0;
    addr_valid = 1'b1; da = 48'h6655_4433_2200;
    @(negedge clk);
    da = 48'hffff_ffff_ffff;
    for (int c = 0; c < 3; c++) begin
      chk("R10", "held valid", 32'(res_valid), 1);
      chk("R10", "stall ready", 32'(addr_ready), 0);
      chk("R10", "held src", 32'(res_src), 32'(ea[5:3]));
      chk("R10", "held idx", 32'(res_idx), 32'(ea[2:0]));
      @(negedge clk);
    end
    res_ready = 1'b1;
    @(negedge clk);
    addr_valid = 1'b0;
    chk("R10", "next valid", 32'(res_valid), 1);
    chk("R10", "next src", 32'(res_src), 32'(eb[5:3]));
    @(negedge clk);
    chk("R10", "drained", 32'(res_valid), 0);
  endtask

  task automatic t_sweep;
    for (int m = 0; m < 4; m++) begin
      set_ctrl(m[0], m[1]);
      set_hash({$urandom, $urandom});
      for (int n = 0; n < 24; n++) begin
        logic [47:0] d;
        d = {16'($urandom), $urandom};
        if (n % 6 == 0) d = sh_ent[3];
        send(d, "R9");
      end
    end
  endtask

  initial begin
    for (int i = 0; i < N; i++) sh_ent[i] = '0;
    sh_hash = '0; sh_copy = 0; sh_amc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_exact;
    t_bcast;
    t_hash;
    t_unicast;
    t_allmulti;
    t_promisc;
    t_backpressure;
    t_sweep;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule